// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR flash. It decides whether an embedded program or erase operation has finished, and whether it succeeded or failed. After a start pulse it reads the device status byte through a simple request/acknowledge port, always in pairs. It compares the toggle bit (bit 6) of the two reads in a pair. While the toggle bit keeps flipping it watches the exceeded-timing-limit bit (bit 5).

The toggle bit can stop at the same moment the limit bit rises. For that reason, a set limit bit does not fail the operation at once. It triggers one more read pair. The operation fails only if that recheck pair still toggles. On a failure the block asks for a reset-command write, so that the device returns to array reads. It waits for that write to be acknowledged before it reports the result.

A programmable bound on the number of toggling pairs stops the loop if the device never settles. An abort input abandons a check. Any later check then starts from nothing.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, `rd_req`, `rst_cmd_req`, `done`, `pass`, `fail` and `timed_out` are all 0.
- R2: In the cycle after a `start` pulse is taken, `rd_req` is 1. The request stays high until `rd_ack`. Reads are consumed strictly in pairs.
- R3: If bit 6 is equal in the two reads of a pair, `done` pulses one cycle after the second acknowledge, with `pass`=1 and `fail`=0.
- R4: If bit 6 differs and bit 5 of the second read is 0, another pair is read and no result is given.
- R5: If bit 6 differs and bit 5 of the second read is 1, a recheck pair is read. If bit 6 is equal in that pair, the result is pass.
- R6: If bit 6 still differs in the recheck pair, `rst_cmd_req` rises and is held until `rst_cmd_ack`. Then `done` pulses with `fail`=1 and `timed_out`=0. No read is requested while the reset command is pending.
- R7: `abort` during a read phase returns the block to idle with no `done`. A later start keeps no stored toggle value and no recheck state from the abandoned check.
- R8: When the count of toggling pairs with bit 5 at 0 reaches `max_polls` (a value of 0 acts as 1), `done` pulses with `fail`=1 and `timed_out`=1, and no reset command is issued.
- R9: `start` is ignored while a check is in progress.
- R10: `done` lasts one cycle. `pass`, `fail` and `timed_out` hold their values until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a status check (pulse) |
| abort | input | 1 | Abandon the check in progress |
| max_polls | input | CNT_W | Bound on toggling pairs with bit 5 low |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Status read complete, `rd_data` valid |
| rd_data | input | 8 | Status byte returned by the read |
| rst_cmd_req | output | 1 | Request a reset-command write to the device |
| rst_cmd_ack | input | 1 | Reset-command write complete |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | Operation completed successfully |
| fail | output | 1 | Operation failed or timed out |
| timed_out | output | 1 | Failure was due to the poll bound |

## Verification
A wrong stored toggle bit or a stale recheck flag shows up at the ports within one read pair. The visible signs are the wrong verdict on `done`, a missing or extra `rst_cmd_req`, or a difference in how many status bytes are consumed before `done`. Each scenario therefore checks the verdict flags, the count of reset commands and the number of reads consumed. A poll counter that is off by one moves the timeout by exactly one pair, so the scenarios sit on both sides of the bound. State left over after an abort shows in the very next check as a false failure.

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [CNT_W-1:0] max_polls,
  output logic             rd_req,
  input  logic             rd_ack,
  input  logic [7:0]       rd_data,
  output logic             rst_cmd_req,
  input  logic             rst_cmd_ack,
  output logic             done,
  output logic             pass,
  output logic             fail,
  output logic             timed_out
);

  typedef enum logic [1:0] {S_IDLE, S_RD1, S_RD2, S_RST} st_t;

  st_t              st;
  logic             tgl_q;
  logic             recheck_q;
  logic [CNT_W-1:0] pairs_q;
  logic             unused_bits;

  wire              same     = (rd_data[6] == tgl_q);
  wire [CNT_W-1:0]  pairs_nx = pairs_q + 1'b1;
  wire              at_limit = (pairs_nx >= max_polls);

  assign rd_req      = (st == S_RD1) || (st == S_RD2);
  assign rst_cmd_req = (st == S_RST);
  assign unused_bits = ^{rd_data[7], rd_data[4:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tgl_q     <= 1'b0;
      recheck_q <= 1'b0;
      pairs_q   <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      timed_out <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st        <= S_RD1;
          tgl_q     <= 1'b0;
          recheck_q <= 1'b0;
          pairs_q   <= '0;
          pass      <= 1'b0;
          fail      <= 1'b0;
          timed_out <= 1'b0;
        end
        S_RD1: begin
          if (abort) st <= S_IDLE;
          else if (rd_ack) begin
            tgl_q <= rd_data[6];
            st    <= S_RD2;
          end
        end
        S_RD2: begin
          if (abort) st <= S_IDLE;
          else if (rd_ack) begin
            if (same) begin
              done <= 1'b1;
              pass <= 1'b1;
              st   <= S_IDLE;
            end else if (recheck_q) begin
              st <= S_RST;
            end else if (rd_data[5]) begin
              recheck_q <= 1'b1;
              st        <= S_RD1;
            end else if (at_limit) begin
              done      <= 1'b1;
              fail      <= 1'b1;
              timed_out <= 1'b1;
              st        <= S_IDLE;
            end else begin
              pairs_q <= pairs_nx;
              st      <= S_RD1;
            end
          end
        end
        S_RST: if (rst_cmd_ack) begin
          done <= 1'b1;
          fail <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/toggle_poll_ctrl_chk.sv
module toggle_poll_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic abort,
  input logic rd_req,
  input logic rd_ack,
  input logic rst_cmd_req,
  input logic rst_cmd_ack,
  input logic done,
  input logic pass,
  input logic fail,
  input logic timed_out
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_VERDICT_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (pass ^ fail)); // R3
  AST_RDREQ_HELD:     assert property (@(posedge clk) disable iff (!rst_n) (rd_req && !rd_ack && !abort) |=> rd_req); // R2
  AST_RSTCMD_HELD:    assert property (@(posedge clk) disable iff (!rst_n) (rst_cmd_req && !rst_cmd_ack) |=> rst_cmd_req); // R6
  AST_NO_RD_IN_RST:   assert property (@(posedge clk) disable iff (!rst_n) !(rd_req && rst_cmd_req)); // R6
  AST_FAIL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n) (done && fail && !timed_out) |-> $past(rst_cmd_req && rst_cmd_ack)); // R6
  AST_TMO_IS_FAIL:    assert property (@(posedge clk) disable iff (!rst_n) timed_out |-> (fail && !pass)); // R8
  AST_ABORT_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) (rd_req && abort) |=> (!rd_req && !done)); // R7

endmodule

bind toggle_poll_ctrl toggle_poll_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .rd_req(rd_req), .rd_ack(rd_ack),
  .rst_cmd_req(rst_cmd_req), .rst_cmd_ack(rst_cmd_ack), .done(done),
  .pass(pass), .fail(fail), .timed_out(timed_out)
);

// File: tb/test_toggle_poll_ctrl.sv
module test_toggle_poll_ctrl;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0;
  logic [CNT_W-1:0] max_polls = 16'd10;
  logic rd_req, rd_ack = 1'b0, rst_cmd_req, rst_cmd_ack = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic done, pass, fail, timed_out;

  typedef struct { logic p; logic f; logic t; int rst; string tag; } exp_t;
  exp_t   expq[$];
  logic [7:0] rdq[$];
  int checks = 0, errors = 0, rst_seen = 0, rst_wait = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  toggle_poll_ctrl #(.CNT_W(CNT_W)) i_toggle_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .max_polls(max_polls),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
    .rst_cmd_req(rst_cmd_req), .rst_cmd_ack(rst_cmd_ack),
    .done(done), .pass(pass), .fail(fail), .timed_out(timed_out));

  task automatic chk(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // status read responder
  always @(negedge clk) begin
    if (rd_req && rdq.size() > 0) begin
      rd_ack  <= 1'b1;
      rd_data <= rdq.pop_front();
    end else begin
      rd_ack <= 1'b0;
    end
  end

  // reset-command responder: acknowledges after three cycles
  always @(negedge clk) begin
    if (rst_cmd_ack) rst_cmd_ack <= 1'b0;
    else if (rst_cmd_req) begin
      rst_wait++;
      if (rst_wait == 3) begin
        rst_cmd_ack <= 1'b1;
        rst_seen++;
        rst_wait = 0;
      end
    end else rst_wait = 0;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R7", $sformatf("unexpected done p=%0b f=%0b t=%0b, expected none", pass, fail, timed_out));
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(pass == e.p && fail == e.f && timed_out == e.t && rst_seen == e.rst, e.tag,
            $sformatf("got p=%0b f=%0b t=%0b rst=%0d, expected p=%0b f=%0b t=%0b rst=%0d",
                      pass, fail, timed_out, rst_seen, e.p, e.f, e.t, e.rst));
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run(input logic [7:0] bytes[], input int maxp, input logic p, input logic f,
                     input logic t, input int rst_exp, input string tag);
    exp_t e;
    max_polls = CNT_W'(maxp);
    foreach (bytes[i]) rdq.push_back(bytes[i]);
    e.p = p; e.f = f; e.t = t; e.rst = rst_exp; e.tag = tag;
    expq.push_back(e);
    pulse_start();
    while (expq.size() != 0) @(negedge clk);
    chk(rdq.size() == 0, tag, $sformatf("reads left unconsumed %0d, expected 0", rdq.size()));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "R2", "watchdog expired, expected completion");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_req && !rst_cmd_req && !done && !pass && !fail && !timed_out, "R1",
        $sformatf("outputs %b%b%b%b%b%b, expected 000000", rd_req, rst_cmd_req, done, pass, fail, timed_out));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rd_req, "R1", $sformatf("rd_req=%0b, expected 0", rd_req));

    // R2: request after start, held while not acknowledged
    pulse_start();
    chk(rd_req, "R2", $sformatf("rd_req=%0b after start, expected 1", rd_req));
    repeat (5) @(negedge clk);
    chk(rd_req && !done, "R2", $sformatf("rd_req=%0b done=%0b while stalled, expected 1/0", rd_req, done));
    abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    chk(!rd_req, "R7", $sformatf("rd_req=%0b after abort, expected 0", rd_req));
    repeat (4) @(negedge clk);

    run('{8'h40, 8'h40}, 10, 1, 0, 0, 0, "R3");
    run('{8'h00, 8'h00}, 10, 1, 0, 0, 0, "R3");
    // R10: verdict held, cleared on next start
    repeat (5) @(negedge clk);
    chk(pass && !fail && !done, "R10", $sformatf("p=%0b f=%0b d=%0b, expected 1/0/0", pass, fail, done));
    run('{8'h00, 8'h40, 8'h40, 8'h00, 8'h00, 8'h00}, 10, 1, 0, 0, 0, "R4");
    run('{8'h00, 8'h60, 8'h40, 8'h40}, 10, 1, 0, 0, 0, "R5");
    run('{8'h00, 8'h60, 8'h00, 8'h40}, 10, 0, 1, 0, 1, "R6");
    chk(fail && !pass, "R10", $sformatf("p=%0b f=%0b held, expected 0/1", pass, fail));
    pulse_start();
    chk(!pass && !fail && !timed_out, "R10", $sformatf("p=%0b f=%0b t=%0b after start, expected 000", pass, fail, timed_out));
    abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    repeat (3) @(negedge clk);

    run('{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40}, 3, 0, 1, 1, 1, "R8");
    run('{8'h00, 8'h40, 8'h00, 8'h40, 8'h40, 8'h40}, 3, 1, 0, 0, 1, "R8");
    run('{8'h00, 8'h40}, 0, 0, 1, 1, 1, "R8");
    chk(!rst_cmd_req && rst_seen == 1, "R8", $sformatf("reset commands %0d, expected 1", rst_seen));

    // R9: second start mid-check must not clear the recheck state
    begin
      exp_t e;
      max_polls = 16'd10;
      rdq.push_back(8'h00); rdq.push_back(8'h60);
      e.p = 0; e.f = 1; e.t = 0; e.rst = 2; e.tag = "R9";
      expq.push_back(e);
      pulse_start();
      repeat (6) @(negedge clk);
      pulse_start();
      repeat (2) @(negedge clk);
      rdq.push_back(8'h00); rdq.push_back(8'h40);
      while (expq.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
    end

    // R7: abort after limit bit seen; new check must start fresh
    rdq.push_back(8'h00); rdq.push_back(8'h60);
    pulse_start();
    repeat (8) @(negedge clk);
    chk(rd_req && !done, "R7", $sformatf("rd_req=%0b done=%0b before abort, expected 1/0", rd_req, done));
    abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    repeat (6) @(negedge clk);
    chk(!rd_req && !rst_cmd_req, "R7", $sformatf("req %0b%0b after abort, expected 00", rd_req, rst_cmd_req));
    run('{8'h00, 8'h40, 8'h40, 8'h40}, 10, 1, 0, 0, 2, "R7");

    if (!finished) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end
endmodule